// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block handles the interrupt side of a memory-mapped UART. It keeps an 11-bit raw interrupt status and an 11-bit enable mask. Their bitwise AND is the masked status, which is computed rather than stored. A single interrupt request line, `irq`, is derived from the masked status. A small register port gives software access to the data, flag, mask, raw-status, masked-status and clear registers. Side-band signals from the receive path report that a byte has arrived and whether input is waiting. The serial shifter, baud generator and FIFOs are not part of this block. The transmitter is treated as always ready, and there is no receive FIFO.

The request line follows a three-state machine. In `IRQ_QUIET` the masked set is empty and `irq` is low. The transition *arm* happens when the masked set becomes non-empty; it moves to `IRQ_COUNTING` and loads a down-counter. While counting, further masked changes that keep the set non-empty neither reload nor restart the counter. The transition *expire* happens when the counter reaches zero; it moves to `IRQ_RAISED`, where `irq` is high. The transitions *cancel* (from `IRQ_COUNTING`) and *drop* (from `IRQ_RAISED`) both return to `IRQ_QUIET` when the masked set empties. In `IRQ_RAISED`, `irq` is gated by the masked status, so the line falls in the same cycle the set empties.

Register reads are combinational from the address in the same cycle. Writes and read side effects take effect at the next rising clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The interrupt bits are numbered as follows: ring 0, clear-to-send change 1, carrier change 2, data-set-ready change 3, receive 4, transmit 5, receive timeout 6, framing 7, parity 8, break 9, overrun 10. The mask is read at offset 0x038, the raw status at 0x03C and the masked status (raw AND mask) at 0x040. Bits 15..11 of all three read as zero.
- R2: After reset, the raw status and the mask are zero, `irq` is low and the state is `IRQ_QUIET`.
- R3: Writing offset 0x044 clears each raw bit whose written bit is 1. All other raw bits are left unchanged.
- R4: `irq` rises DELAY_CYCLES+1 rising edges after the edge that made the masked set non-empty. Masked changes while an assertion is pending do not move that time.
- R5: `irq` falls in the same cycle the masked set becomes empty. If the set empties before the count expires, the pending assertion is cancelled, and a later non-empty set waits the full delay again.
- R6: A write to offset 0x000 leaves raw transmit bit 5 set, and pulses `tx_valid` with `tx_byte` equal to the written bits 7..0.
- R7: A `rx_strobe` pulse sets raw bits 4 and 6.
- R8: Reading offset 0x000 while `rx_avail` is high returns `rx_byte` in bits 7..0, pulses `rx_pop`, and clears raw bits 4 and 6. Without input, the read returns zero and leaves the raw status unchanged.
- R9: The flag register at 0x018 reads bit 0 (clear to send) as 1 and bit 7 (transmit empty) as 1. Bit 4 (receive empty) reads as the inverse of `rx_avail`. All other bits read as 0.
- R10: Writing the mask at 0x038 changes only the mask; the request line is then re-evaluated against the existing raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| rx_avail | input | 1 | An input byte is waiting |
| rx_byte | input | 8 | The waiting input byte |
| rx_strobe | input | 1 | One-cycle pulse: new input has arrived |
| rx_pop | output | 1 | The waiting byte is consumed by this read |
| tx_valid | output | 1 | One-cycle pulse: byte to transmit |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the same cycle as the request. The bench drives each access at a falling edge and samples one nanosecond later, well before the rising edge. Register updates and side effects land at the next rising edge, so the following access observes them. The request line is checked one nanosecond after every rising edge, starting at the write that arms it. It must read low through edge DELAY_CYCLES and high from edge DELAY_CYCLES+1. Drops are checked just after the edge of the clearing write, and receive strobes are injected in mid-count to show that the rise time does not move.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int IRQ_W = 11;

    localparam int IRQ_RING    = 0;
    localparam int IRQ_CTSCHG  = 1;
    localparam int IRQ_CARCHG  = 2;
    localparam int IRQ_DSRCHG  = 3;
    localparam int IRQ_RX      = 4;
    localparam int IRQ_TX      = 5;
    localparam int IRQ_RXTO    = 6;
    localparam int IRQ_FRAME   = 7;
    localparam int IRQ_PARITY  = 8;
    localparam int IRQ_BREAK   = 9;
    localparam int IRQ_OVERRUN = 10;

    localparam int OFS_DATA = 'h000;
    localparam int OFS_FLAG = 'h018;
    localparam int OFS_MASK = 'h038;
    localparam int OFS_RAW  = 'h03C;
    localparam int OFS_MSKD = 'h040;
    localparam int OFS_CLR  = 'h044;

    localparam int FLG_CTS  = 0;
    localparam int FLG_RXE  = 4;
    localparam int FLG_TXE  = 7;

    typedef enum logic [1:0] {
        IRQ_QUIET    = 2'd0,
        IRQ_COUNTING = 2'd1,
        IRQ_RAISED   = 2'd2
    } irq_state_e;

    typedef struct packed {
        logic wr_data;
        logic rd_data;
        logic wr_mask;
        logic wr_clr;
    } bus_stb_t;

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_stb_t          stb
);

    always_comb begin
        stb         = '0;
        stb.wr_data = sel &&  wr && (addr == ADDR_W'(OFS_DATA));
        stb.rd_data = sel && !wr && (addr == ADDR_W'(OFS_DATA));
        stb.wr_mask = sel &&  wr && (addr == ADDR_W'(OFS_MASK));
        stb.wr_clr  = sel &&  wr && (addr == ADDR_W'(OFS_CLR));
    end

endmodule

// File: rtl/uirq_status.sv
module uirq_status
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  bus_stb_t         stb,
    input  logic [IRQ_W-1:0] wbits,
    input  logic             rx_avail,
    input  logic             rx_strobe,
    output logic [IRQ_W-1:0] raw_q,
    output logic [IRQ_W-1:0] mask_q
);

    logic [IRQ_W-1:0] clr_bits;
    logic [IRQ_W-1:0] set_bits;
    logic [IRQ_W-1:0] raw_d;
    logic [IRQ_W-1:0] mask_d;

    always_comb begin
        clr_bits = '0;
        set_bits = '0;
        if (stb.wr_clr) begin
            clr_bits = wbits;
        end
        if (stb.rd_data && rx_avail) begin
            clr_bits[IRQ_RX]   = 1'b1;
            clr_bits[IRQ_RXTO] = 1'b1;
        end
        if (stb.wr_data) begin
            clr_bits[IRQ_TX] = 1'b1;
            set_bits[IRQ_TX] = 1'b1;
        end
        if (rx_strobe) begin
            set_bits[IRQ_RX]   = 1'b1;
            set_bits[IRQ_RXTO] = 1'b1;
        end
        raw_d  = (raw_q & ~clr_bits) | set_bits;
        mask_d = stb.wr_mask ? wbits : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= raw_d;
            mask_q <= mask_d;
        end
    end

    assert_clear_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr_clr && !rx_strobe) |=> ((raw_q & $past(wbits)) == '0));

    assert_tx_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb.wr_data |=> raw_q[IRQ_TX]);

    assert_rx_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> (raw_q[IRQ_RX] && raw_q[IRQ_RXTO]));

    assert_mask_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr_mask && !rx_strobe) |=> $stable(raw_q));

endmodule

// File: rtl/uirq_delay_fsm.sv
module uirq_delay_fsm
    import uirq_pkg::*;
#(
    parameter int DELAY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_masked,
    output logic irq
);

    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYCLES - 1);

    irq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (any_masked) begin
                    state_d = IRQ_COUNTING;
                    cnt_d   = CNT_LOAD;
                end
            end
            IRQ_COUNTING: begin
                if (!any_masked) begin
                    state_d = IRQ_QUIET;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = IRQ_RAISED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            IRQ_RAISED: begin
                if (!any_masked) begin
                    state_d = IRQ_QUIET;
                end
            end
            default: begin
                state_d = IRQ_QUIET;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED) && any_masked;
    end

    assert_rise_after_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state_q) == IRQ_COUNTING));

    assert_no_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_COUNTING && any_masked && cnt_q != '0)
            |=> (state_q == IRQ_COUNTING && cnt_q == $past(cnt_q) - 1'b1));

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != IRQ_QUIET && !any_masked) |=> (state_q == IRQ_QUIET));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 16,
    parameter int DELAY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_avail,
    input  logic [7:0]        rx_byte,
    input  logic              rx_strobe,
    output logic              rx_pop,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq
);

    bus_stb_t         stb;
    logic [IRQ_W-1:0] raw_q;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] masked;
    logic             any_masked;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:IRQ_W];

    uirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .stb  (stb)
    );

    uirq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .wbits     (bus_wdata[IRQ_W-1:0]),
        .rx_avail  (rx_avail),
        .rx_strobe (rx_strobe),
        .raw_q     (raw_q),
        .mask_q    (mask_q)
    );

    assign masked     = raw_q & mask_q;
    assign any_masked = |masked;

    uirq_delay_fsm #(.DELAY_CYCLES(DELAY_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_masked (any_masked),
        .irq        (irq)
    );

    assign rx_pop   = stb.rd_data && rx_avail;
    assign tx_valid = stb.wr_data;
    assign tx_byte  = bus_wdata[7:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_DATA): if (rx_avail) bus_rdata[7:0] = rx_byte;
                ADDR_W'(OFS_FLAG): begin
                    bus_rdata[FLG_CTS] = 1'b1;
                    bus_rdata[FLG_TXE] = 1'b1;
                    bus_rdata[FLG_RXE] = !rx_avail;
                end
                ADDR_W'(OFS_MASK): bus_rdata[IRQ_W-1:0] = mask_q;
                ADDR_W'(OFS_RAW):  bus_rdata[IRQ_W-1:0] = raw_q;
                ADDR_W'(OFS_MSKD): bus_rdata[IRQ_W-1:0] = masked;
                default:           bus_rdata = '0;
            endcase
        end
    end

    assert_status_high_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_RAW) || bus_addr == ADDR_W'(OFS_MSKD)
            || bus_addr == ADDR_W'(OFS_MASK))) |-> (bus_rdata[DATA_W-1:IRQ_W] == '0));

    assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw_q & mask_q) != '0));

endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    localparam int D = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_avail = 1'b0, rx_strobe = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_pop, tx_valid, irq;
    logic [7:0]  tx_byte;

    int n_chk = 0, n_bad = 0;
    logic       got_pop, got_txv;
    logic [7:0] got_txb;
    logic [15:0] rd;

    always #2 clk = ~clk;

    uart_irq_ctrl #(.ADDR_W(12), .DATA_W(16), .DELAY_CYCLES(D)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
        .rx_pop(rx_pop), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic [11:0] a, input logic [15:0] d,
                          output logic [15:0] r);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        r = bus_rdata; got_pop = rx_pop; got_txv = tx_valid; got_txb = tx_byte;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Called right after the arming edge; optional strobe before edge strobe_at.
    task automatic check_rise(input int strobe_at, input string req);
        check(req, {15'd0, irq}, 16'd0);
        for (int i = 1; i <= D + 1; i++) begin
            @(negedge clk);
            rx_strobe = (i == strobe_at);
            @(posedge clk);
            #1;
            check(req, {15'd0, irq}, {15'd0, (i > D)});
        end
        rx_strobe = 1'b0;
    endtask

    // {req, wr, addr, wdata, expected}
    localparam logic [48:0] VEC [15] = '{
        {4'd2,  1'b0, 12'h03C, 16'h0000, 16'h0000},  // R2 raw
        {4'd2,  1'b0, 12'h038, 16'h0000, 16'h0000},  // R2 mask
        {4'd2,  1'b0, 12'h040, 16'h0000, 16'h0000},  // R2 masked
        {4'd9,  1'b0, 12'h018, 16'h0000, 16'h0091},  // R9 no input
        {4'd1,  1'b1, 12'h038, 16'hFFFF, 16'h0000},
        {4'd1,  1'b0, 12'h038, 16'h0000, 16'h07FF},  // R1 high bits zero
        {4'd6,  1'b1, 12'h000, 16'h0041, 16'h0000},
        {4'd6,  1'b0, 12'h03C, 16'h0000, 16'h0020},  // R6 tx raw set
        {4'd1,  1'b0, 12'h040, 16'h0000, 16'h0020},  // R1 masked AND
        {4'd10, 1'b1, 12'h038, 16'h0010, 16'h0000},
        {4'd10, 1'b0, 12'h040, 16'h0000, 16'h0000},  // R10 masked follows mask
        {4'd10, 1'b0, 12'h03C, 16'h0000, 16'h0020},  // R10 raw untouched
        {4'd3,  1'b1, 12'h044, 16'h0020, 16'h0000},
        {4'd3,  1'b0, 12'h03C, 16'h0000, 16'h0000},  // R3 cleared
        {4'd8,  1'b0, 12'h000, 16'h0000, 16'h0000}   // R8 no input
    };

    logic done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2 irq reset", {15'd0, irq}, 16'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int v = 0; v < 15; v++) begin
            bus_op(VEC[v][44], VEC[v][43:32], VEC[v][31:16], rd);
            if (!VEC[v][44]) begin
                n_chk++;
                if (rd !== VEC[v][15:0]) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d: actual 0x%04h expected 0x%04h",
                             VEC[v][48:45], v, rd, VEC[v][15:0]);
                end
            end
        end

        // Receive path, flags, partial clear
        bus_op(1'b1, 12'h044, 16'h07FF, rd);
        bus_op(1'b1, 12'h038, 16'h0000, rd);
        rx_avail = 1'b1; rx_byte = 8'h5A;
        @(negedge clk); rx_strobe = 1'b1;
        @(negedge clk); rx_strobe = 1'b0;
        bus_op(1'b0, 12'h03C, 16'h0, rd);  check("R7 strobe sets rx bits", rd, 16'h0050);
        bus_op(1'b0, 12'h018, 16'h0, rd);  check("R9 flags with input", rd, 16'h0081);
        bus_op(1'b1, 12'h000, 16'h0033, rd);
        check("R6 tx_valid", {15'd0, got_txv}, 16'd1);
        check("R6 tx_byte", {8'd0, got_txb}, 16'h0033);
        bus_op(1'b1, 12'h044, 16'h0010, rd);
        bus_op(1'b0, 12'h03C, 16'h0, rd);  check("R3 partial clear", rd, 16'h0060);
        bus_op(1'b0, 12'h000, 16'h0, rd);
        check("R8 read byte", rd, 16'h005A);
        check("R8 rx_pop", {15'd0, got_pop}, 16'd1);
        bus_op(1'b0, 12'h03C, 16'h0, rd);  check("R8 rx bits cleared", rd, 16'h0020);
        rx_avail = 1'b0;
        bus_op(1'b0, 12'h000, 16'h0, rd);  check("R8 no pop without input", {15'd0, got_pop}, 16'd0);

        // Delay timing: raw TX set, mask write arms
        bus_op(1'b1, 12'h038, 16'h0020, rd);
        check_rise(0, "R10 R4 mask write arms delay");
        bus_op(1'b1, 12'h044, 16'h0020, rd);
        check("R5 drop at once", {15'd0, irq}, 16'd0);

        // Data write arms, then cancel mid-count, then full delay again
        bus_op(1'b1, 12'h000, 16'h0011, rd);
        @(posedge clk); @(posedge clk); #1;
        bus_op(1'b1, 12'h044, 16'h0020, rd);
        check("R5 cancelled", {15'd0, irq}, 16'd0);
        bus_op(1'b1, 12'h000, 16'h0012, rd);
        check_rise(0, "R5 R6 restart full delay");

        // No reschedule while pending
        bus_op(1'b1, 12'h044, 16'h07FF, rd);
        bus_op(1'b1, 12'h038, 16'h0070, rd);
        bus_op(1'b1, 12'h000, 16'h0013, rd);
        check_rise(2, "R4 pending not rescheduled");
        bus_op(1'b0, 12'h040, 16'h0, rd);  check("R1 R7 masked after strobe", rd, 16'h0070);
        bus_op(1'b1, 12'h038, 16'h0000, rd);
        check("R10 mask clear drops irq", {15'd0, irq}, 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule